// File: doc/BRIEF.md
# Stall-Detecting Baseband Watchdog Timer

This block watches a group of signal-processing state machines (radar detection, two receive paths, two transmit paths, gain control and search) and flags a stall when one of them stays in a mode for too long. An activity input tells the watchdog whether the monitored logic is busy or idle. Each mode has its own enable and its own timeout, counted in coarse ticks from a free prescaler of `2^TICK_LOG2` clock cycles. When the counter of the current mode reaches its budget, the watchdog freezes a packed copy of all seven 4-bit machine states together with a cause code, raises a hang flag, and can then drive a level interrupt and a one-cycle chip-reset request.

Software reaches the block through three 32-bit registers chosen by a 2-bit select: status (select 0), control 1 (select 1) and control 2 (select 2). Read data is combinational from the select. A read strobe on the status register restarts the timer. A write to status with bit 3 at zero clears the hang flag. Changing control 1 or flipping the activity input also starts a fresh timeout.

Top module: `stall_watchdog`

## Requirements
- R1: After reset all three registers read as zero, and `irqOut` and `resetReq` are low.
- R2: Control 1 layout: bit 0 enables busy-mode monitoring and bits [15:2] hold the busy timeout L in ticks. With `busy` high, bit 0 set and L > 0, the hang flag (status bit 3) first reads 1 exactly L·2^TICK_LOG2 cycles after the clock edge that wrote control 1.
- R3: Control 1 bit 1 enables idle-mode monitoring and bits [31:16] hold the idle timeout. With `busy` low, expiry follows the same timing as R2, and the busy timeout field has no effect.
- R4: A mode whose enable bit is clear, or whose timeout field is zero, never expires.
- R5: Any change of `busy` restarts the count, so expiry falls L ticks after the edge that saw the change.
- R6: A read strobe (`regRd`) with select 0 restarts the count.
- R7: On expiry, status [31:4] take `smState` as sampled at the expiry edge (radar [7:4], first receive [11:8], second receive [15:12], first transmit [19:16], second transmit [23:20], gain control [27:24], search [31:28]), and status [2:0] take 3'b001 for a busy-mode expiry or 3'b010 for an idle-mode expiry.
- R8: Writing status with bit 3 at zero clears the hang flag, the cause code and the snapshot. Writing status with bit 3 set changes nothing.
- R9: `irqOut` is a level that equals the hang flag ANDed with control 2 bit 2.
- R10: `resetReq` is high for exactly one cycle, the first cycle in which the hang flag reads 1, and only when control 2 bit 1 is set.
- R11: Control 1 and control 2 store all 32 written bits and read them back unchanged.
- R12: While the hang flag is set, the counter is stopped and the status word does not change, whatever `smState` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 status, 1 control 1, 2 control 2 |
| regWr | input | 1 | Write strobe for the selected register |
| regRd | input | 1 | Read strobe; with select 0 it restarts the timer |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register |
| busy | input | 1 | Activity of the monitored logic (1 busy, 0 idle) |
| smState | input | 28 | Seven packed 4-bit machine states, radar in [3:0] up to search in [27:24] |
| irqOut | output | 1 | Level interrupt |
| resetReq | output | 1 | One-cycle chip-reset request |

## Verification
On every cycle the assertions check that the active count stays below its budget, that a restart leaves the prescaler and counter at zero, that the counter and the snapshot stay frozen while the hang flag is set, that a clear takes effect on the next cycle, and that the reset request never lasts longer than one cycle. Only the bench scenarios can show the exact expiry cycle for each timeout, that a mode change or status read moves the deadline, that a disabled mode or zero budget never fires, and that the captured fields sit at the right bit positions. The bench sweeps the busy and idle timeouts across several values with a 3-bit prescaler and computes each deadline as the budget times eight.

// File: rtl/wd_pkg.sv
package wd_pkg;
  // Register selects
  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_CTL1   = 2'd1;
  localparam logic [1:0] SEL_CTL2   = 2'd2;

  // Control 1 fields
  localparam int BUSY_EN_BIT  = 0;
  localparam int IDLE_EN_BIT  = 1;
  localparam int BUSY_LIM_LO  = 2;
  localparam int BUSY_LIM_HI  = 15;
  localparam int IDLE_LIM_LO  = 16;
  localparam int IDLE_LIM_HI  = 31;

  // Control 2 fields
  localparam int RST_EN_BIT   = 1;
  localparam int IRQ_EN_BIT   = 2;

  // Status fields
  localparam int HANG_BIT     = 3;
  localparam int SNAP_LO      = 4;

  // Cause codes
  localparam logic [2:0] CAUSE_BUSY = 3'b001;
  localparam logic [2:0] CAUSE_IDLE = 3'b010;

  // Control-to-datapath strobes
  typedef struct packed {
    logic restart;
    logic capture;
    logic captureBusy;
    logic clearHang;
  } wd_strobe_t;
endpackage

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
#(
  parameter int TICK_LOG2 = 15,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] regWdata,
  input  logic             busy,
  input  logic             hangQ,
  output logic [REG_W-1:0] ctl1Q,
  output logic [REG_W-1:0] ctl2Q,
  output wd_strobe_t       strobe
);
  localparam int CNT_W  = IDLE_LIM_HI - IDLE_LIM_LO + 1;
  localparam int BLIM_W = BUSY_LIM_HI - BUSY_LIM_LO + 1;

  logic [TICK_LOG2-1:0] preQ;
  logic [CNT_W-1:0]     cntQ;
  logic                 busyQ;

  logic             ctl1Hit, ctl2Hit, statusRead, statusWrite, modeChange;
  logic             restart, modeOn, active, tick, expire;
  logic [CNT_W-1:0] limit;

  always_comb begin
    ctl1Hit     = regWr && (regSel == SEL_CTL1);
    ctl2Hit     = regWr && (regSel == SEL_CTL2);
    statusWrite = regWr && (regSel == SEL_STATUS);
    statusRead  = regRd && (regSel == SEL_STATUS);
    modeChange  = busy != busyQ;
    restart     = ctl1Hit || statusRead || modeChange;
    modeOn      = busy ? ctl1Q[BUSY_EN_BIT] : ctl1Q[IDLE_EN_BIT];
    limit       = busy ? {{(CNT_W-BLIM_W){1'b0}}, ctl1Q[BUSY_LIM_HI:BUSY_LIM_LO]}
                       : ctl1Q[IDLE_LIM_HI:IDLE_LIM_LO];
    active      = modeOn && (limit != '0) && !hangQ;
    tick        = active && (preQ == '1);
    expire      = tick && (cntQ == limit - {{(CNT_W-1){1'b0}}, 1'b1});
  end

  always_comb begin
    strobe.restart     = restart;
    strobe.capture     = expire && !restart;
    strobe.captureBusy = busy;
    strobe.clearHang   = statusWrite && !regWdata[HANG_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl1Q <= '0;
      ctl2Q <= '0;
      busyQ <= 1'b0;
    end else begin
      busyQ <= busy;
      if (ctl1Hit) ctl1Q <= regWdata;
      if (ctl2Hit) ctl2Q <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (restart || expire) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (active) begin
      preQ <= preQ + 1'b1;
      if (tick) cntQ <= cntQ + 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cntQ < limit));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cntQ == '0) && (preQ == '0));

  // R12
  frozen_in_hang_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hangQ && !restart) |=> $stable(cntQ) && $stable(preQ));
endmodule

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int NUM_SM = 7,
  parameter int SM_W   = 4,
  parameter int REG_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wd_strobe_t             strobe,
  input  logic [NUM_SM*SM_W-1:0] smState,
  input  logic [REG_W-1:0]       ctl1Q,
  input  logic [REG_W-1:0]       ctl2Q,
  input  logic [1:0]             regSel,
  output logic [REG_W-1:0]       regRdata,
  output logic                   hangQ,
  output logic                   irqOut,
  output logic                   resetReq
);
  localparam int SNAP_W = NUM_SM * SM_W;

  logic [2:0]        causeQ;
  logic [SNAP_W-1:0] snapQ;
  logic              pulseQ;
  logic [REG_W-1:0]  statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hangQ  <= 1'b0;
      causeQ <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobe.capture && ctl2Q[RST_EN_BIT];
      if (strobe.capture) begin
        hangQ  <= 1'b1;
        causeQ <= strobe.captureBusy ? CAUSE_BUSY : CAUSE_IDLE;
      end else if (strobe.clearHang) begin
        hangQ  <= 1'b0;
        causeQ <= '0;
      end
    end
  end

  for (genvar i = 0; i < NUM_SM; i++) begin : g_snap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 snapQ[i*SM_W +: SM_W] <= '0;
      else if (strobe.capture)   snapQ[i*SM_W +: SM_W] <= smState[i*SM_W +: SM_W];
      else if (strobe.clearHang) snapQ[i*SM_W +: SM_W] <= '0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[2:0]                    = causeQ;
    statusWord[HANG_BIT]               = hangQ;
    statusWord[SNAP_LO +: SNAP_W]      = snapQ;
    unique case (regSel)
      SEL_STATUS: regRdata = statusWord;
      SEL_CTL1:   regRdata = ctl1Q;
      SEL_CTL2:   regRdata = ctl2Q;
      default:    regRdata = '0;
    endcase
    irqOut   = hangQ && ctl2Q[IRQ_EN_BIT];
    resetReq = pulseQ;
  end

  // R12
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hangQ && !strobe.clearHang) |=> hangQ && $stable(snapQ) && $stable(causeQ));

  // R8
  clear_hang_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearHang && !strobe.capture) |=> !hangQ);

  // R10
  reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R7
  capture_sets_hang_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> hangQ && (causeQ != '0));
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog
  import wd_pkg::*;
#(
  parameter int TICK_LOG2 = 15,
  parameter int NUM_SM    = 7,
  parameter int SM_W      = 4,
  parameter int REG_W     = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             regSel,
  input  logic                   regWr,
  input  logic                   regRd,
  input  logic [REG_W-1:0]       regWdata,
  output logic [REG_W-1:0]       regRdata,
  input  logic                   busy,
  input  logic [NUM_SM*SM_W-1:0] smState,
  output logic                   irqOut,
  output logic                   resetReq
);
  wd_strobe_t       strobe;
  logic [REG_W-1:0] ctl1Q, ctl2Q;
  logic             hangQ;

  wd_control #(.TICK_LOG2(TICK_LOG2), .REG_W(REG_W)) u_control (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .busy(busy), .hangQ(hangQ),
    .ctl1Q(ctl1Q), .ctl2Q(ctl2Q), .strobe(strobe)
  );

  wd_datapath #(.NUM_SM(NUM_SM), .SM_W(SM_W), .REG_W(REG_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .smState(smState),
    .ctl1Q(ctl1Q), .ctl2Q(ctl2Q), .regSel(regSel), .regRdata(regRdata),
    .hangQ(hangQ), .irqOut(irqOut), .resetReq(resetReq)
  );
endmodule

// File: tb/stall_watchdog_bench.sv
`timescale 1ns/1ps
module stall_watchdog_bench;
  localparam int TL   = 3;
  localparam int TICK = 1 << TL;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busy = 1'b0;
  logic [27:0] smState = '0;
  logic        irqOut, resetReq;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stall_watchdog #(.TICK_LOG2(TL)) u_stall_watchdog (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .smState(smState),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] d);
    regSel = sel;
    #0.5;
    d = regRdata;
  endtask

  task automatic readStrobe();
    @(negedge clk);
    regSel = 2'd0; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  function automatic logic [27:0] pat(input int k);
    return 28'h1234567 ^ (28'h0A5C3E1 * k);
  endfunction

  logic [31:0] rd, expStat;

  initial begin
    #200000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    peek(2'd0, rd); check("R1 status", rd, 32'h0);
    peek(2'd1, rd); check("R1 ctl1", rd, 32'h0);
    peek(2'd2, rd); check("R1 ctl2", rd, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 rst", {31'b0, resetReq}, 32'h0);

    // R11 readback
    writeReg(2'd2, 32'hA5A5_5A5B);
    peek(2'd2, rd); check("R11 ctl2", rd, 32'hA5A5_5A5B);
    writeReg(2'd1, 32'h3C00_0000);
    peek(2'd1, rd); check("R11 ctl1", rd, 32'h3C00_0000);
    writeReg(2'd2, 32'h0000_0006);

    // R2 busy sweep, R7 capture, R9 irq, R10 reset pulse, R12 hold, R8 clear
    busy = 1'b1;
    for (int L = 1; L <= 5; L++) begin
      smState = pat(L);
      step(2);
      writeReg(2'd1, (32'(L) << 2) | 32'h1);
      step(TICK*L - 1);
      peek(2'd0, rd); check("R2 before deadline", rd, 32'h0);
      check("R10 no early pulse", {31'b0, resetReq}, 32'h0);
      step(1);
      expStat = {pat(L), 1'b1, 3'b001};
      peek(2'd0, rd); check("R2 R7 busy expiry", rd, expStat);
      check("R9 irq", {31'b0, irqOut}, 32'h1);
      check("R10 pulse", {31'b0, resetReq}, 32'h1);
      step(1);
      check("R10 single", {31'b0, resetReq}, 32'h0);
      smState = ~pat(L);
      step(TICK*L + 3);
      peek(2'd0, rd); check("R12 held", rd, expStat);
      if (L == 2) begin
        writeReg(2'd0, 32'h0000_0008);
        peek(2'd0, rd); check("R8 bit3 set ignored", rd, expStat);
      end
      writeReg(2'd0, 32'h0);
      peek(2'd0, rd); check("R8 clear", rd, 32'h0);
      check("R9 irq low", {31'b0, irqOut}, 32'h0);
    end

    // R3 idle sweep, irq only (R10 disabled)
    busy = 1'b0;
    writeReg(2'd2, 32'h0000_0004);
    for (int L = 1; L <= 4; L++) begin
      smState = pat(L + 9);
      step(2);
      writeReg(2'd1, (32'(L) << 16) | (32'd7 << 2) | 32'h2);
      step(TICK*L - 1);
      peek(2'd0, rd); check("R3 before deadline", rd, 32'h0);
      step(1);
      peek(2'd0, rd); check("R3 R7 idle expiry", rd, {pat(L + 9), 1'b1, 3'b010});
      check("R9 irq idle", {31'b0, irqOut}, 32'h1);
      check("R10 disabled", {31'b0, resetReq}, 32'h0);
      writeReg(2'd0, 32'h0);
    end

    // R4 disabled modes and zero budgets
    writeReg(2'd1, (32'd3 << 16) | (32'd3 << 2));
    step(100);
    peek(2'd0, rd); check("R4 idle disabled", rd, 32'h0);
    busy = 1'b1;
    step(100);
    peek(2'd0, rd); check("R4 busy disabled", rd, 32'h0);
    writeReg(2'd1, 32'h1);
    step(100);
    peek(2'd0, rd); check("R4 busy zero budget", rd, 32'h0);
    busy = 1'b0;
    writeReg(2'd1, 32'h2);
    step(100);
    peek(2'd0, rd); check("R4 idle zero budget", rd, 32'h0);

    // R5 mode change restarts
    writeReg(2'd2, 32'h0000_0006);
    busy = 1'b1;
    step(2);
    writeReg(2'd1, (32'd4 << 2) | 32'h1);
    step(20);
    busy = 1'b0;
    step(3);
    busy = 1'b1;
    step(TICK*4);
    peek(2'd0, rd); check("R5 moved deadline", rd, 32'h0);
    step(1);
    peek(2'd0, rd); check("R5 expiry after change", rd[3:0], 32'h9);
    writeReg(2'd0, 32'h0);

    // R6 status read restarts
    writeReg(2'd1, (32'd4 << 2) | 32'h1);
    step(20);
    readStrobe();
    step(TICK*4 - 1);
    peek(2'd0, rd); check("R6 moved deadline", rd, 32'h0);
    step(1);
    peek(2'd0, rd); check("R6 expiry after read", rd[3:0], 32'h9);
    writeReg(2'd0, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule